// File: doc/BRIEF.md
# JTAG Tunnel Frame Decoder

This block sits behind a user data register of an outer JTAG TAP and unpacks scans that a debug host tunnels through that register toward a nested debug transport TAP. When the outer instruction register holds the tunnel opcode, the block watches the capture, shift and update strobes. Each data scan is read as a self-describing frame:
- one scan-type bit, which picks an instruction-register scan or a data-register scan on the inner TAP;
- a 7-bit length, sent LSB first;
- that many payload bits;
- a short tail that is ignored.

The payload is forwarded bit by bit to the inner TAP over a plain serial data and shift-enable interface. A one-cycle update pulse is issued once the full payload has arrived and the outer update strobe is seen. The inner TAP's serial output is registered back onto the outer TDO.

All logic runs in the TCK domain, and each clock edge is one TCK. The output path is registered, so returned data lags the shifted-in data by one TCK. For that reason a host clocks one more bit than the length field states and drops the first captured bit. Typical frames are a 5-bit inner instruction scan and a 32-bit inner control scan; the second carries a length of 32 with 33 clocked payload bits.

Top module: `tunnel_frame_decoder`

## Requirements
- R1: While reset is high and on the first edge after it, tdo_o, inner_tdi_o, inner_shift_o, inner_dr_o and inner_update_o are all 0.
- R2: Capture, shift and update strobes have no effect unless outer_ir_i equals the 6-bit tunnel opcode 0x23. When it does not, inner_shift_o and inner_update_o stay 0 and tdo_o and inner_dr_o hold their values.
- R3: Capture clears inner_dr_o to 0. The first shifted bit after capture is the scan type: 0 means an instruction scan and 1 means a data scan. inner_dr_o shows that bit from the edge that samples it until the next capture.
- R4: Shifted bits 1 to 7 of a frame form the payload length, LSB first. Exactly that many following bits are forwarded. Each is forwarded in the cycle after its shift edge, with inner_shift_o at 1 and inner_tdi_o equal to the bit, in arrival order. Header bits are never forwarded.
- R5: Bits shifted after the last payload bit are not forwarded. This covers the extra lag bit and the trailing zeros.
- R6: An update strobe after a complete frame (full header, nonzero length, full payload) makes inner_update_o 1 for exactly the cycle after the update edge.
- R7: No inner update is issued when the header has fewer than 8 bits, the length is 0, or fewer payload bits than the length were shifted.
- R8: After every selected shift edge, tdo_o equals the inner_tdo_i value sampled at that edge. At all other times it holds.
- R9: A capture in the middle of a frame abandons it, and the next frame is parsed from its first bit.
- R10: The frame bit counter saturates. However long the tail is, earlier bit positions are never seen again, so the tail is never forwarded and the update is not lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | TCK |
| rst_i | input | 1 | Synchronous active-high reset |
| outer_ir_i | input | 6 | Current outer instruction register value |
| capture_i | input | 1 | Outer TAP in Capture-DR |
| shift_i | input | 1 | Outer TAP in Shift-DR |
| update_i | input | 1 | Outer TAP in Update-DR |
| tdi_i | input | 1 | Outer serial data in |
| tdo_o | output | 1 | Outer serial data out (registered inner TDO) |
| inner_tdi_o | output | 1 | Serial data to the inner TAP |
| inner_shift_o | output | 1 | Inner shift enable, one pulse per payload bit |
| inner_dr_o | output | 1 | Inner scan type: 0 = instruction, 1 = data |
| inner_update_o | output | 1 | One-cycle update pulse to the inner TAP |
| inner_tdo_i | input | 1 | Serial data from the inner TAP |

## Verification
Frames are driven with a range of shapes, each of which separates a different fault:
- 5-bit instruction scans against 32-bit, 41-bit and 127-bit data scans, to separate scan-type handling and length decoding at the small, typical and largest lengths;
- a 1-bit payload, to expose off-by-one errors at the header/payload boundary.

Frames with a zero length, a header cut short, a payload cut short, and a wrong outer opcode show whether the update gate and the opcode decode are wrong. A capture in the middle of a frame, and a tail of more than 500 bits, test whether the parse restarts correctly and whether the counter wraps. The returned TDO is compared on every shift against an alternating inner pattern, which shows whether the one-TCK lag is present.

// File: rtl/tun_pkg.sv
`timescale 1ns/1ps
package tun_pkg;
  typedef enum logic {SCAN_IR = 1'b0, SCAN_DR = 1'b1} scan_kind_e;
  localparam int unsigned KIND_BITS = 1;
endpackage

// File: rtl/tun_hdr_parse.sv
`timescale 1ns/1ps
module tun_hdr_parse
  import tun_pkg::*;
#(
  parameter int unsigned LEN_W = 7,
  parameter int unsigned CNT_W = LEN_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             en_i,
  input  logic             capture_i,
  input  logic             shift_i,
  input  logic             tdi_i,
  output scan_kind_e       kind_o,
  output logic [LEN_W-1:0] len_o,
  output logic             pay_o,
  output logic             done_o
);
  localparam int unsigned HDR = KIND_BITS + LEN_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] HDR_C = CNT_W'(HDR);

  logic [CNT_W-1:0] cnt_q;
  logic [LEN_W-1:0] len_q;
  scan_kind_e       kind_q;
  logic [CNT_W-1:0] pay_end_w;

  assign pay_end_w = HDR_C + CNT_W'(len_q);

  always_ff @(posedge clk_i) begin
    if (rst_i || (en_i && capture_i)) begin
      cnt_q  <= '0;
      len_q  <= '0;
      kind_q <= SCAN_IR;
    end else if (en_i && shift_i) begin
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      if (cnt_q == '0) kind_q <= scan_kind_e'(tdi_i);
      for (int i = 0; i < int'(LEN_W); i++) begin
        if (cnt_q == CNT_W'(i + 1)) len_q[i] <= tdi_i;
      end
    end
  end

  assign kind_o = kind_q;
  assign len_o  = len_q;
  assign pay_o  = en_i && shift_i && !capture_i && (cnt_q >= HDR_C) && (cnt_q < pay_end_w);
  assign done_o = (len_q != '0) && (cnt_q >= pay_end_w);

  // R4: length field frozen once header is complete
  p_len_frozen_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_i && shift_i && !capture_i && cnt_q >= HDR_C) |=> $stable(len_q));
  // R10: saturated counter stays saturated until capture
  p_cnt_sat_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    (cnt_q == CNT_MAX && !(en_i && capture_i)) |=> (cnt_q == CNT_MAX));
  // R3: scan type only changes on the first bit or at capture
  p_kind_hold_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (cnt_q != '0 && !(en_i && capture_i)) |=> $stable(kind_q));
endmodule

// File: rtl/tun_fwd.sv
`timescale 1ns/1ps
module tun_fwd (
  input  logic clk_i,
  input  logic rst_i,
  input  logic pay_i,
  input  logic sh_i,
  input  logic tdi_i,
  input  logic upd_req_i,
  input  logic inner_tdo_i,
  output logic tdo_o,
  output logic inner_tdi_o,
  output logic inner_shift_o,
  output logic inner_update_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      tdo_o          <= 1'b0;
      inner_tdi_o    <= 1'b0;
      inner_shift_o  <= 1'b0;
      inner_update_o <= 1'b0;
    end else begin
      if (sh_i) tdo_o <= inner_tdo_i;
      if (pay_i) inner_tdi_o <= tdi_i;
      inner_shift_o  <= pay_i;
      inner_update_o <= upd_req_i;
    end
  end

  // R5: a forwarded bit always comes from a selected shift
  p_fwd_from_shift_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    inner_shift_o |-> $past(sh_i));
endmodule

// File: rtl/tunnel_frame_decoder.sv
`timescale 1ns/1ps
module tunnel_frame_decoder
  import tun_pkg::*;
#(
  parameter int unsigned OIR_W = 6,
  parameter logic [OIR_W-1:0] TUNNEL_OP = 6'h23,
  parameter int unsigned LEN_W = 7,
  parameter int unsigned CNT_W = LEN_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [OIR_W-1:0] outer_ir_i,
  input  logic             capture_i,
  input  logic             shift_i,
  input  logic             update_i,
  input  logic             tdi_i,
  output logic             tdo_o,
  output logic             inner_tdi_o,
  output logic             inner_shift_o,
  output logic             inner_dr_o,
  output logic             inner_update_o,
  input  logic             inner_tdo_i
);
  logic             sel_w;
  logic             sh_w;
  logic             pay_w;
  logic             done_w;
  logic             upd_req_w;
  logic [LEN_W-1:0] len_w;
  scan_kind_e       kind_w;

  assign sel_w     = (outer_ir_i == TUNNEL_OP);
  assign sh_w      = sel_w && shift_i;
  assign upd_req_w = sel_w && update_i && done_w;

  tun_hdr_parse #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_hdr (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .en_i      (sel_w),
    .capture_i (capture_i),
    .shift_i   (shift_i),
    .tdi_i     (tdi_i),
    .kind_o    (kind_w),
    .len_o     (len_w),
    .pay_o     (pay_w),
    .done_o    (done_w)
  );

  tun_fwd u_fwd (
    .clk_i          (clk_i),
    .rst_i          (rst_i),
    .pay_i          (pay_w),
    .sh_i           (sh_w),
    .tdi_i          (tdi_i),
    .upd_req_i      (upd_req_w),
    .inner_tdo_i    (inner_tdo_i),
    .tdo_o          (tdo_o),
    .inner_tdi_o    (inner_tdi_o),
    .inner_shift_o  (inner_shift_o),
    .inner_update_o (inner_update_o)
  );

  assign inner_dr_o = (kind_w == SCAN_DR);

  // R6: inner update only follows a selected update strobe
  p_upd_src_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    inner_update_o |-> $past(sel_w && update_i));
  // R7: inner update never for a zero length
  p_upd_len_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    inner_update_o |-> ($past(len_w) != '0));
  // R2: no forwarding unless the tunnel opcode is selected
  p_shift_src_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    inner_shift_o |-> $past(sel_w && shift_i));
  // R8: outer TDO holds outside selected shifts
  p_tdo_hold_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(sel_w && shift_i) |-> $stable(tdo_o));
endmodule

// File: tb/tunnel_frame_decoder_tb.sv
`timescale 1ns/1ps
module tunnel_frame_decoder_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic [5:0] outer_ir;
  logic       capture, shift, update, tdi, inner_tdo;
  logic       tdo, i_tdi, i_shift, i_dr, i_upd;
  int         nchecks = 0;
  int         nfail = 0;

  always #2.5 clk = ~clk;

  tunnel_frame_decoder u_dut (
    .clk_i(clk), .rst_i(rst), .outer_ir_i(outer_ir), .capture_i(capture),
    .shift_i(shift), .update_i(update), .tdi_i(tdi), .tdo_o(tdo),
    .inner_tdi_o(i_tdi), .inner_shift_o(i_shift), .inner_dr_o(i_dr),
    .inner_update_o(i_upd), .inner_tdo_i(inner_tdo)
  );

  typedef struct packed {
    logic [5:0]  ir;
    logic        kind;
    logic [6:0]  len;
    logic [63:0] pl;
    logic [3:0]  hdr_n;
    logic [7:0]  pay_n;
    logic [3:0]  trail_n;
    logic        exp_upd;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{6'h23, 1'b0, 7'd5,   64'h11,                  4'd8, 8'd6,   4'd3, 1'b1},
    '{6'h23, 1'b1, 7'd32,  64'hA5C3_0F96,           4'd8, 8'd33,  4'd3, 1'b1},
    '{6'h23, 1'b1, 7'd41,  64'h0123_4567_89AB,      4'd8, 8'd42,  4'd3, 1'b1},
    '{6'h23, 1'b1, 7'd0,   64'h1,                   4'd8, 8'd1,   4'd3, 1'b0},
    '{6'h23, 1'b1, 7'd12,  64'h0,                   4'd5, 8'd0,   4'd0, 1'b0},
    '{6'h23, 1'b1, 7'd10,  64'h3FF,                 4'd8, 8'd6,   4'd0, 1'b0},
    '{6'h22, 1'b1, 7'd8,   64'hFF,                  4'd8, 8'd9,   4'd3, 1'b0},
    '{6'h23, 1'b0, 7'd1,   64'h1,                   4'd8, 8'd2,   4'd3, 1'b1},
    '{6'h23, 1'b1, 7'd127, 64'hDEAD_BEEF_1357_9BDF, 4'd8, 8'd128, 4'd3, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchecks++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // one shift; checks forwarding and TDO return
  task automatic shift_one(input logic b, input logic sel, input logic fwd, input string req);
    logic prev_tdo, pat;
    prev_tdo  = tdo;
    pat       = ~prev_tdo;
    tdi       = b;
    inner_tdo = pat;
    shift     = 1'b1;
    step();
    chk({req, " fwd"}, 32'(i_shift), 32'(fwd));
    if (fwd) chk({req, " inner_tdi"}, 32'(i_tdi), 32'(b));
    chk("R8 tdo return", 32'(tdo), sel ? 32'(pat) : 32'(prev_tdo));
  endtask

  task automatic run_frame(input vec_t v);
    logic sel, prev_dr;
    sel      = (v.ir == 6'h23);
    prev_dr  = i_dr;
    outer_ir = v.ir;
    capture  = 1'b1;
    step();
    capture = 1'b0;
    if (sel) chk("R3 capture clears type", 32'(i_dr), 32'd0);
    for (int i = 0; i < int'(v.hdr_n); i++) begin
      logic hb;
      hb = (i == 0) ? v.kind : v.len[i-1];
      shift_one(hb, sel, 1'b0, "R4 header");
      if (i == 0) chk("R3/R2 scan type", 32'(i_dr), sel ? 32'(v.kind) : 32'(prev_dr));
    end
    for (int k = 0; k < int'(v.pay_n); k++) begin
      logic fwd;
      fwd = sel && (v.hdr_n == 4'd8) && (k < int'(v.len));
      shift_one(v.pl[k % 64], sel, fwd, fwd ? "R4 payload" : "R5 lag bit");
    end
    for (int t = 0; t < int'(v.trail_n); t++) shift_one(1'b0, sel, 1'b0, "R5 trail");
    shift  = 1'b0;
    update = 1'b1;
    step();
    update = 1'b0;
    chk("R6/R7 inner update", 32'(i_upd), 32'(v.exp_upd));
    step();
    chk("R6 update one cycle", 32'(i_upd), 32'd0);
  endtask

  initial begin
    #1000000;
    nfail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfail);
    $finish;
  end

  initial begin
    rst = 1'b1; outer_ir = 6'h23; capture = 0; shift = 0; update = 0; tdi = 0; inner_tdo = 1;
    repeat (4) step();
    chk("R1 tdo reset", 32'(tdo), 32'd0);
    chk("R1 shift reset", 32'(i_shift), 32'd0);
    chk("R1 dr reset", 32'(i_dr), 32'd0);
    chk("R1 upd reset", 32'(i_upd), 32'd0);
    chk("R1 tdi reset", 32'(i_tdi), 32'd0);
    rst = 1'b0;
    step();
    chk("R1 first edge after reset", 32'({tdo, i_shift, i_dr, i_upd, i_tdi}), 32'd0);

    for (int n = 0; n < NV; n++) run_frame(VECS[n]);

    // R9: abandon a data-scan frame in mid-payload, then an instruction scan
    outer_ir = 6'h23;
    capture = 1'b1; step(); capture = 1'b0;
    shift_one(1'b1, 1'b1, 1'b0, "R9 pre hdr");
    for (int i = 0; i < 7; i++) shift_one(i == 2, 1'b1, 1'b0, "R9 pre hdr");
    shift_one(1'b1, 1'b1, 1'b1, "R9 pre payload");
    shift_one(1'b0, 1'b1, 1'b1, "R9 pre payload");
    shift = 1'b0;
    run_frame('{6'h23, 1'b0, 7'd2, 64'h2, 4'd8, 8'd3, 4'd3, 1'b1});

    // R10: very long tail must not wrap the counter
    capture = 1'b1; step(); capture = 1'b0;
    shift_one(1'b1, 1'b1, 1'b0, "R10 hdr");
    for (int i = 0; i < 7; i++) shift_one(i < 2, 1'b1, 1'b0, "R10 hdr");
    for (int k = 0; k < 3; k++) shift_one(k[0], 1'b1, 1'b1, "R10 payload");
    begin
      int extra;
      extra = 0;
      tdi = 1'b1;
      shift = 1'b1;
      for (int t = 0; t < 520; t++) begin
        step();
        if (i_shift) extra++;
      end
      chk("R10 tail never forwarded", 32'(extra), 32'd0);
      chk("R10 scan type kept", 32'(i_dr), 32'd1);
    end
    shift = 1'b0; update = 1'b1; step(); update = 1'b0;
    chk("R10 update after long tail", 32'(i_upd), 32'd1);
    step();

    $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfail);
    $finish;
  end
endmodule